// File: doc/BRIEF.md
# Write-Before-Read Register File

This block is the integer register file of a five-stage in-order pipeline: 32 registers of 32 bits, two read ports whose data follows their addresses combinationally, and one write port that updates storage on the rising clock edge. The decode stage drives the two read addresses. The writeback stage drives the write address, the write data and the write enable.

When the writeback stage writes a register in the same cycle that decode reads it, the read port returns the value being written instead of the stale stored one. The result matches a file that writes in the first half of the cycle and reads in the second half. A local forwarding multiplexer on each read port does this, so a consumer in decode can overlap its producer in writeback with no stall. Register 0 is hard-wired to zero. A write aimed at register 0 is dropped and never forwarded. A synchronous active-high reset clears every register.

Top module: `wbr_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared, so afterwards every nonzero address reads 0 on both ports until it is written.
- R2: With `wr_en` = 1 and a nonzero `wr_addr` at a rising edge, `wr_data` is stored and is returned from the next cycle on by either read port that addresses it.
- R3: With `wr_en` = 0 at a rising edge, no register changes.
- R4: Address 0 always reads as zero on both ports. A write to address 0 changes nothing.
- R5: In the same cycle that `wr_en` = 1 and `wr_addr` is nonzero and equals a read address, that read port returns `wr_data`. This holds for each port on its own and for both at once.
- R6: No forwarding happens when `wr_en` = 0 or `wr_addr` = 0. In that case the read port returns the stored value, even when the addresses match.
- R7: A read port whose address differs from `wr_addr` returns the stored value, whatever is being written in that cycle.
- R8: Read data depends combinationally on the read address and becomes valid in the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| rd_addr_a | input | 5 | Register index for read port A |
| rd_data_a | output | 32 | Combinational read data, port A |
| rd_addr_b | input | 5 | Register index for read port B |
| rd_data_b | output | 32 | Combinational read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register index written at the rising edge |
| wr_data | input | 32 | Value to write |

## Verification
Every address is written in a sweep. In each step port A reads the address being written and port B reads a neighbour. This separates a correct forward from a stale array read, and shows that a write does not disturb other registers. A full readback with a second, inverted pattern then shows which values were actually stored. Matching addresses with the enable low, and enabled writes to register 0, show whether forwarding is correctly withheld. Address changes made between clock edges, and resets issued after registers hold data, cover combinational reads and clearing.

// File: rtl/wbr_rf_pkg.sv
package wbr_rf_pkg;
  // Source selected for one read port
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_ARRAY  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/wbr_rf_array.sv
module wbr_rf_array #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              live_wr;

  assign live_wr = wr_en && (wr_addr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (live_wr) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_data[p*DATA_W +: DATA_W] = mem[rd_addr[p*ADDR_W +: ADDR_W]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en && wr_addr != '0) |=> (mem[$past(wr_addr)] == $past(wr_data))); // R2

  AST_ENTRY0_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rst |-> (mem[0] == '0)); // R4

  for (genvar e = 0; e < DEPTH; e++) begin : g_keep
    AST_ENTRY_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!rst && !(wr_en && wr_addr == e)) |=> $stable(mem[e])); // R3
  end
endmodule

// File: rtl/wbr_rf_fwd.sv
module wbr_rf_fwd
  import wbr_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  rd_src_e src;

  always_comb begin
    if (rd_addr == '0)                         src = SRC_ZERO;
    else if (wr_en && (wr_addr == rd_addr))    src = SRC_BYPASS;
    else                                       src = SRC_ARRAY;
  end

  always_comb begin
    case (src)
      SRC_ZERO:   rd_data = '0;
      SRC_BYPASS: rd_data = wr_data;
      default:    rd_data = arr_data;
    endcase
  end

  AST_ZERO_PORT: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == '0) |-> (rd_data == '0)); // R4

  AST_FWD_HIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && wr_addr == rd_addr) |-> (rd_data == wr_data)); // R5

  AST_NO_FALSE_FWD: assert property (@(posedge clk) disable iff (rst)
    ((!wr_en || wr_addr == '0) && rd_addr != '0) |-> (rd_data == arr_data)); // R6

  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != wr_addr && rd_addr != '0) |-> (rd_data == arr_data)); // R7
endmodule

// File: rtl/wbr_regfile.sv
module wbr_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NUM_RD = 2;

  logic [NUM_RD*ADDR_W-1:0] addr_flat;
  logic [NUM_RD*DATA_W-1:0] arr_flat;
  logic [NUM_RD*DATA_W-1:0] out_flat;

  assign addr_flat = {rd_addr_b, rd_addr_a};
  assign rd_data_a = out_flat[0 +: DATA_W];
  assign rd_data_b = out_flat[DATA_W +: DATA_W];

  wbr_rf_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)
  ) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_flat), .rd_data(arr_flat)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    wbr_rf_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
      .clk(clk), .rst(rst),
      .rd_addr(addr_flat[p*ADDR_W +: ADDR_W]),
      .arr_data(arr_flat[p*DATA_W +: DATA_W]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data(out_flat[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: tb/sim_wbr_regfile.sv
module sim_wbr_regfile;
  localparam int PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int N = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic          wr_en = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [N];

  wbr_regfile #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(int i, logic [DW-1:0] seed);
    return (32'h9E37_79B1 * (i + 1)) ^ seed;
  endfunction

  function automatic logic [DW-1:0] expect_rd(logic [AW-1:0] ra);
    if (ra == '0) return '0;
    if (wr_en && wr_addr == ra) return wr_data;
    return mdl[ra];
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check after settling, model the edge
  task automatic cyc(string req, logic we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                     logic [AW-1:0] ra, logic [AW-1:0] rb);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_addr_a = ra; rd_addr_b = rb;
    #1;
    chk({req, " port A"}, rd_data_a, expect_rd(ra));
    chk({req, " port B"}, rd_data_b, expect_rd(rb));
    if (we && wa != '0) mdl[wa] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: all registers read zero after reset
    for (int i = 0; i < N; i++) cyc("R1 reset", 1'b0, '0, '0, AW'(i), AW'(N-1-i));

    // R5 forward on A, R7 neighbour on B, R4 for address 0
    for (int i = 0; i < N; i++)
      cyc("R5 fwd sweep", 1'b1, AW'(i), pat(i, 32'h0), AW'(i), AW'((i+1) % N));

    // R2 readback of stored values
    for (int i = 0; i < N; i++) cyc("R2 readback", 1'b0, '0, '0, AW'(i), AW'(N-1-i));

    // R6 / R3: matching address with enable low, then confirm no change
    for (int i = 1; i < N; i++) begin
      cyc("R6 no fwd when disabled", 1'b0, AW'(i), ~pat(i, 32'h0), AW'(i), AW'(i));
      cyc("R3 unchanged", 1'b0, '0, '0, AW'(i), AW'(i));
    end

    // R4: write to register 0 is dropped and never forwarded
    cyc("R4 zero write", 1'b1, '0, 32'hDEAD_BEEF, '0, '0);
    cyc("R4 zero after", 1'b0, '0, 32'hDEAD_BEEF, '0, '0);
    chk("R4 zero port A", rd_data_a, 32'h0);

    // R5 forward on both ports at once, inverted pattern, R7 via readback
    for (int i = 1; i < N; i++)
      cyc("R5 dual fwd", 1'b1, AW'(i), pat(i, 32'hFFFF_FFFF), AW'(i), AW'(i));
    for (int i = 0; i < N; i++) cyc("R7 second readback", 1'b0, '0, '0, AW'(i), AW'((i+7) % N));

    // R8: combinational read without a clock edge
    @(negedge clk);
    wr_en = 1'b0;
    rd_addr_a = 5'd3; #1; chk("R8 comb A", rd_data_a, mdl[3]);
    rd_addr_a = 5'd9; #1; chk("R8 comb A", rd_data_a, mdl[9]);
    rd_addr_b = 5'd17; #1; chk("R8 comb B", rd_data_b, mdl[17]);

    // R1: reset after data is present
    do_reset();
    for (int i = 0; i < N; i++) cyc("R1 reset again", 1'b0, '0, '0, AW'(i), AW'(i));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule